// File: doc/BRIEF.md
# CORDIC Coprocessor Sequencer

This block is a small multicycle instruction engine that steps through a stored program of 16-bit words and uses it to feed a CORDIC arithmetic unit. The unit itself sits outside. The block holds the program counter, the instruction register, a program store, eight 32-bit working registers and a 512-word data store. It reaches the arithmetic unit through three operand buses, a one-cycle launch pulse, a completion flag and a result bus.

After reset the engine sits in a setup phase. In that phase a host port may write the working registers, the data store and the program store. A pulse on `start` clears the program counter and begins the fetch, decode and execute loop. The loop runs until a halt instruction freezes it. The host read port stays usable at all times, so results can be collected after the halt.

Top module: `cordic_seq_top`

## Requirements
- R1: After reset, `pc` is 0, `halted` is 0 and `cor_start` is 0.
- R2: Host writes (`host_we` with `host_sel` 0 for registers, 1 for the data store, 2 for the program store) take effect only before `start` is seen. Once `start` is seen, host writes are ignored until the next reset.
- R3: Opcode 0000 in bits 15:12 loads working register bits 11:9 from the data-store word addressed by bits 8:0.
- R4: Opcode 0001 writes the working register named by bits 11:9 into the data-store word addressed by bits 8:0.
- R5: Opcode 0010 places register bits 8:6, 5:3 and 2:0 on `cor_x`, `cor_y` and `cor_z`. The operands are held steady while the engine waits. The engine then waits any number of cycles for `cor_done`, and only after that writes `cor_result` into the register named by bits 11:9.
- R6: Each opcode-0010 instruction raises `cor_start` for exactly one cycle.
- R7: Opcode 0011 adds bits 11:0, read as a signed two's-complement value, to the address of the jump instruction itself.
- R8: Opcode 0100 tests the register named by bits 11:9. If it is zero, the engine adds bits 8:0 (signed) to the address of the branch. Otherwise it continues at the next word.
- R9: Opcode 0110 stops execution. `halted` goes high and `pc` stays at the halt's address until reset. Further `start` pulses have no effect.
- R10: Any opcode from 0111 to 1111 behaves as a no-operation.
- R11: Opcode 0101 does nothing and moves to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins execution from the setup phase |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host target: 0 registers, 1 data store, 2 program store |
| host_addr | input | 12 | Host word address (low bits used for smaller stores) |
| host_wdata | input | 32 | Host write data (low 16 bits for the program store) |
| host_rdata | output | 32 | Combinational read of the selected store at `host_addr` |
| cor_x | output | 32 | First operand to the arithmetic unit |
| cor_y | output | 32 | Second operand to the arithmetic unit |
| cor_z | output | 32 | Third operand to the arithmetic unit |
| cor_start | output | 1 | One-cycle launch pulse |
| cor_done | input | 1 | Arithmetic unit completion flag |
| cor_result | input | 32 | Result, valid with `cor_done` |
| pc | output | 12 | Current program counter |
| halted | output | 1 | High once a halt has executed |

## Verification
The checks on operand stability and write-back assume that the arithmetic unit raises `cor_done` only in a cycle after it has seen `cor_start`. They also assume it raises `cor_done` only once per launch. The bench's model of the unit keeps to this: it waits a configurable latency of at least one cycle after the pulse, then raises the flag for one cycle. The host drives `start` only from the setup phase, with the program store filled beforehand. It performs its ignored writes only once the engine has halted.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
    localparam int INSN_W  = 16;
    localparam int RF_AW   = 3;
    localparam int DM_AW   = 9;

    typedef enum logic [3:0] {
        ST_SETUP  = 4'd0,
        ST_FETCH  = 4'd1,
        ST_DECODE = 4'd2,
        ST_LDA    = 4'd3,
        ST_LDB    = 4'd4,
        ST_STORE  = 4'd5,
        ST_CA     = 4'd6,
        ST_CB     = 4'd7,
        ST_CC     = 4'd8,
        ST_CWAIT  = 4'd9,
        ST_CWB    = 4'd10,
        ST_JUMP   = 4'd11,
        ST_BRA    = 4'd12,
        ST_BRB    = 4'd13,
        ST_IDLE   = 4'd14,
        ST_STOP   = 4'd15
    } seq_state_e;

    localparam logic [3:0] OP_LOAD  = 4'b0000;
    localparam logic [3:0] OP_STORE = 4'b0001;
    localparam logic [3:0] OP_CALC  = 4'b0010;
    localparam logic [3:0] OP_JUMP  = 4'b0011;
    localparam logic [3:0] OP_BZ    = 4'b0100;
    localparam logic [3:0] OP_NOP   = 4'b0101;
    localparam logic [3:0] OP_STOP  = 4'b0110;
endpackage

// File: rtl/cseq_store.sv
module cseq_store #(
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic [AW-1:0] r0_addr,
    output logic [DW-1:0] r0_data,
    input  logic [AW-1:0] r1_addr,
    output logic [DW-1:0] r1_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) begin
            mem_q[a_addr] <= a_wdata;
        end else if (b_we) begin
            mem_q[b_addr] <= b_wdata;
        end
    end

    assign r0_data = mem_q[r0_addr];
    assign r1_data = mem_q[r1_addr];

    // host and engine never write in the same cycle (R2)
    p_one_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_we, b_we}));
endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
    import cseq_pkg::*;
#(
    parameter int PC_W = 12,
    parameter int DW   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [INSN_W-1:0]   imem_rdata,
    output logic [PC_W-1:0]     pc,
    output logic [RF_AW-1:0]    rf_raddr,
    input  logic [DW-1:0]       rf_rdata,
    output logic                rf_we,
    output logic [RF_AW-1:0]    rf_waddr,
    output logic [DW-1:0]       rf_wdata,
    output logic [DM_AW-1:0]    dm_addr,
    input  logic [DW-1:0]       dm_rdata,
    output logic                dm_we,
    output logic [DW-1:0]       dm_wdata,
    output logic [DW-1:0]       cor_x,
    output logic [DW-1:0]       cor_y,
    output logic [DW-1:0]       cor_z,
    output logic                cor_start,
    input  logic                cor_done,
    input  logic [DW-1:0]       cor_result,
    output logic                in_setup,
    output logic                halted
);
    typedef struct packed {
        seq_state_e       state;
        logic [PC_W-1:0]  pc;
        logic [INSN_W-1:0] ir;
        logic [DW-1:0]    mdr;
        logic [DW-1:0]    ox;
        logic [DW-1:0]    oy;
        logic [DW-1:0]    oz;
        logic [DW-1:0]    res;
        logic             go;
        logic             zf;
        logic             halted;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [3:0]       opc;
    logic [PC_W-1:0]  jmp_off;
    logic [PC_W-1:0]  brz_off;
    logic [PC_W-1:0]  pc_inc;

    assign opc     = r_q.ir[15:12];
    assign jmp_off = PC_W'($signed(r_q.ir[11:0]));
    assign brz_off = PC_W'($signed(r_q.ir[8:0]));
    assign pc_inc  = r_q.pc + PC_W'(1);

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        rf_raddr = r_q.ir[11:9];
        rf_we    = 1'b0;
        rf_waddr = r_q.ir[11:9];
        rf_wdata = r_q.mdr;
        dm_addr  = r_q.ir[8:0];
        dm_we    = 1'b0;
        dm_wdata = rf_rdata;

        unique case (r_q.state)
            ST_SETUP: begin
                if (start) begin
                    r_d.pc    = '0;
                    r_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                r_d.ir    = imem_rdata;
                r_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                unique case (opc)
                    OP_LOAD:  begin r_d.pc = pc_inc; r_d.state = ST_LDA;   end
                    OP_STORE: begin r_d.pc = pc_inc; r_d.state = ST_STORE; end
                    OP_CALC:  begin r_d.pc = pc_inc; r_d.state = ST_CA;    end
                    OP_JUMP:  r_d.state = ST_JUMP;
                    OP_BZ:    r_d.state = ST_BRA;
                    OP_STOP:  begin r_d.halted = 1'b1; r_d.state = ST_STOP; end
                    default:  begin r_d.pc = pc_inc; r_d.state = ST_IDLE;  end
                endcase
            end
            ST_LDA: begin
                r_d.mdr   = dm_rdata;
                r_d.state = ST_LDB;
            end
            ST_LDB: begin
                rf_we     = 1'b1;
                r_d.state = ST_FETCH;
            end
            ST_STORE: begin
                dm_we     = 1'b1;
                r_d.state = ST_FETCH;
            end
            ST_CA: begin
                rf_raddr  = r_q.ir[8:6];
                r_d.ox    = rf_rdata;
                r_d.state = ST_CB;
            end
            ST_CB: begin
                rf_raddr  = r_q.ir[5:3];
                r_d.oy    = rf_rdata;
                r_d.state = ST_CC;
            end
            ST_CC: begin
                rf_raddr  = r_q.ir[2:0];
                r_d.oz    = rf_rdata;
                r_d.go    = 1'b1;
                r_d.state = ST_CWAIT;
            end
            ST_CWAIT: begin
                if (cor_done && !r_q.go) begin
                    r_d.res   = cor_result;
                    r_d.state = ST_CWB;
                end
            end
            ST_CWB: begin
                rf_we     = 1'b1;
                rf_wdata  = r_q.res;
                r_d.state = ST_FETCH;
            end
            ST_JUMP: begin
                r_d.pc    = r_q.pc + jmp_off;
                r_d.state = ST_FETCH;
            end
            ST_BRA: begin
                r_d.zf    = (rf_rdata == '0);
                r_d.state = ST_BRB;
            end
            ST_BRB: begin
                r_d.pc    = r_q.zf ? (r_q.pc + brz_off) : pc_inc;
                r_d.state = ST_FETCH;
            end
            ST_IDLE: r_d.state = ST_FETCH;
            ST_STOP: r_d.state = ST_STOP;
            default: r_d.state = ST_SETUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_SETUP;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc        = r_q.pc;
    assign cor_x     = r_q.ox;
    assign cor_y     = r_q.oy;
    assign cor_z     = r_q.oz;
    assign cor_start = r_q.go;
    assign in_setup  = (r_q.state == ST_SETUP);
    assign halted    = r_q.halted;

    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cor_start |=> !cor_start);
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    p_pc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));
    p_operand_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CWAIT && !cor_start) |-> $stable({cor_x, cor_y, cor_z}));
    p_wb_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CWB) |-> $past(cor_done));
endmodule

// File: rtl/cordic_seq_top.sv
module cordic_seq_top
    import cseq_pkg::*;
#(
    parameter int PC_W = 12,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            host_we,
    input  logic [1:0]      host_sel,
    input  logic [PC_W-1:0] host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic [DW-1:0]   cor_x,
    output logic [DW-1:0]   cor_y,
    output logic [DW-1:0]   cor_z,
    output logic            cor_start,
    input  logic            cor_done,
    input  logic [DW-1:0]   cor_result,
    output logic [PC_W-1:0] pc,
    output logic            halted
);
    logic                in_setup;
    logic                h_rf_we, h_dm_we, h_im_we;
    logic [INSN_W-1:0]   im_rdata, im_hdata;
    logic [RF_AW-1:0]    rf_raddr, rf_waddr;
    logic [DW-1:0]       rf_rdata, rf_wdata, rf_hdata;
    logic                rf_we;
    logic [DM_AW-1:0]    dm_addr;
    logic [DW-1:0]       dm_rdata, dm_wdata, dm_hdata;
    logic                dm_we;

    assign h_rf_we = in_setup && host_we && (host_sel == 2'd0);
    assign h_dm_we = in_setup && host_we && (host_sel == 2'd1);
    assign h_im_we = in_setup && host_we && (host_sel == 2'd2);

    cseq_ctrl #(.PC_W(PC_W), .DW(DW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .imem_rdata(im_rdata), .pc(pc),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .dm_addr(dm_addr), .dm_rdata(dm_rdata), .dm_we(dm_we), .dm_wdata(dm_wdata),
        .cor_x(cor_x), .cor_y(cor_y), .cor_z(cor_z),
        .cor_start(cor_start), .cor_done(cor_done), .cor_result(cor_result),
        .in_setup(in_setup), .halted(halted)
    );

    cseq_store #(.AW(RF_AW), .DW(DW)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .a_we(rf_we), .a_addr(rf_waddr), .a_wdata(rf_wdata),
        .b_we(h_rf_we), .b_addr(host_addr[RF_AW-1:0]), .b_wdata(host_wdata),
        .r0_addr(rf_raddr), .r0_data(rf_rdata),
        .r1_addr(host_addr[RF_AW-1:0]), .r1_data(rf_hdata)
    );

    cseq_store #(.AW(DM_AW), .DW(DW)) dm_i (
        .clk(clk), .rst_n(rst_n),
        .a_we(dm_we), .a_addr(dm_addr), .a_wdata(dm_wdata),
        .b_we(h_dm_we), .b_addr(host_addr[DM_AW-1:0]), .b_wdata(host_wdata),
        .r0_addr(dm_addr), .r0_data(dm_rdata),
        .r1_addr(host_addr[DM_AW-1:0]), .r1_data(dm_hdata)
    );

    cseq_store #(.AW(PC_W), .DW(INSN_W)) im_i (
        .clk(clk), .rst_n(rst_n),
        .a_we(h_im_we), .a_addr(host_addr), .a_wdata(host_wdata[INSN_W-1:0]),
        .b_we(1'b0), .b_addr('0), .b_wdata('0),
        .r0_addr(pc), .r0_data(im_rdata),
        .r1_addr(host_addr), .r1_data(im_hdata)
    );

    always_comb begin
        unique case (host_sel)
            2'd0:    host_rdata = rf_hdata;
            2'd1:    host_rdata = dm_hdata;
            2'd2:    host_rdata = DW'(im_hdata);
            default: host_rdata = '0;
        endcase
    end

    // program store is only written during setup (R2)
    p_no_late_prog_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !h_im_we && !h_rf_we && !h_dm_we);
endmodule

// File: tb/cordic_seq_top_tb_top.sv
module cordic_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [31:0] cor_x, cor_y, cor_z, cor_result;
    logic        cor_start;
    logic        cor_done = 1'b0;
    logic [11:0] pc;
    logic        halted;

    int total = 0;
    int bad = 0;
    int lat = 1;
    int launches = 0;
    int start_hi = 0;
    logic [31:0] cap_x [2];
    logic [31:0] cap_y [2];
    logic [31:0] cap_z [2];

    always #5 clk = ~clk;

    cordic_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cor_x(cor_x), .cor_y(cor_y), .cor_z(cor_z),
        .cor_start(cor_start), .cor_done(cor_done), .cor_result(cor_result),
        .pc(pc), .halted(halted)
    );

    function automatic logic [31:0] model_f(logic [31:0] x, logic [31:0] y, logic [31:0] z);
        return (x ^ {y[30:0], 1'b0}) + z;
    endfunction

    // arithmetic unit model: done one cycle, lat cycles after the launch
    initial begin
        cor_result = '0;
        forever begin
            @(negedge clk);
            cor_done = 1'b0;
            if (cor_start) begin
                if (launches < 2) begin
                    cap_x[launches] = cor_x;
                    cap_y[launches] = cor_y;
                    cap_z[launches] = cor_z;
                end
                launches++;
                cor_result = model_f(cor_x, cor_y, cor_z);
                repeat (lat) @(negedge clk);
                cor_done = 1'b1;
            end
        end
    end

    initial forever begin
        @(negedge clk);
        if (cor_start) start_hi++;
    end

    function automatic logic [15:0] e_ld(int rd, int a);  return {4'h0, 3'(rd), 9'(a)}; endfunction
    function automatic logic [15:0] e_st(int rs, int a);  return {4'h1, 3'(rs), 9'(a)}; endfunction
    function automatic logic [15:0] e_cor(int d, int x, int y, int z);
        return {4'h2, 3'(d), 3'(x), 3'(y), 3'(z)};
    endfunction
    function automatic logic [15:0] e_jmp(int off);       return {4'h3, 12'(off)}; endfunction
    function automatic logic [15:0] e_brz(int r, int off); return {4'h4, 3'(r), 9'(off)}; endfunction
    localparam logic [15:0] I_NOP  = 16'h5000;
    localparam logic [15:0] I_HALT = 16'h6000;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic hwrite(int sel, int addr, logic [31:0] data);
        host_sel = 2'(sel); host_addr = 12'(addr); host_wdata = data; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(int sel, int addr, output logic [31:0] data);
        host_sel = 2'(sel); host_addr = 12'(addr);
        #1 data = host_rdata;
    endtask

    task automatic run(string req);
        int n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        total++;
        if (!halted) begin
            bad++;
            $display("FAIL %s actual=running expected=halted", req);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc", 32'(pc), 32'd0);
        check("R1 halted", 32'(halted), 32'd0);
        check("R1 cor_start", 32'(cor_start), 32'd0);
    endtask

    task automatic t_ld_st();
        logic [31:0] v;
        do_reset();
        hwrite(1, 5, 32'hA5A5_1234);
        hwrite(1, 9, 32'h0);
        hwrite(2, 0, 32'(e_ld(2, 5)));
        hwrite(2, 1, 32'(e_st(2, 9)));
        hwrite(2, 2, 32'(I_HALT));
        run("R3");
        hread(0, 2, v); check("R3 load to r2", v, 32'hA5A5_1234);
        hread(1, 9, v); check("R4 store to dm9", v, 32'hA5A5_1234);
    endtask

    task automatic t_cor();
        logic [31:0] v;
        do_reset();
        launches = 0; start_hi = 0;
        hwrite(0, 1, 32'h1111_0001);
        hwrite(0, 2, 32'h0F0F_0202);
        hwrite(0, 3, 32'h0000_0303);
        hwrite(2, 0, 32'(e_cor(4, 1, 2, 3)));
        hwrite(2, 1, 32'(e_cor(5, 3, 1, 2)));
        hwrite(2, 2, 32'(I_HALT));
        lat = 4;
        run("R5");
        lat = 1;
        check("R6 launches", 32'(launches), 32'd2);
        check("R6 pulse cycles", 32'(start_hi), 32'd2);
        check("R5 x0", cap_x[0], 32'h1111_0001);
        check("R5 y0", cap_y[0], 32'h0F0F_0202);
        check("R5 z0", cap_z[0], 32'h0000_0303);
        check("R5 x1", cap_x[1], 32'h0000_0303);
        hread(0, 4, v); check("R5 r4", v, model_f(32'h1111_0001, 32'h0F0F_0202, 32'h0000_0303));
        hread(0, 5, v); check("R5 r5", v, model_f(32'h0000_0303, 32'h1111_0001, 32'h0F0F_0202));
    endtask

    task automatic t_jmp();
        logic [31:0] v;
        do_reset();
        hwrite(1, 21, 32'hBEEF);
        hwrite(0, 1, 32'h7);
        hwrite(2, 0, 32'(e_jmp(3)));
        hwrite(2, 1, 32'(e_st(1, 21)));
        hwrite(2, 2, 32'(I_HALT));
        hwrite(2, 3, 32'(e_jmp(-1)));
        run("R7");
        check("R7 halt pc", 32'(pc), 32'd2);
        hread(1, 21, v); check("R7 skipped marker", v, 32'hBEEF);
    endtask

    task automatic t_brz();
        logic [31:0] v;
        do_reset();
        hwrite(1, 20, 32'hDEAD);
        hwrite(0, 0, 32'h0);
        hwrite(0, 1, 32'h7);
        hwrite(2, 0, 32'(e_brz(1, 5)));
        hwrite(2, 1, 32'(e_brz(0, 3)));
        hwrite(2, 2, 32'(e_st(1, 20)));
        hwrite(2, 3, 32'(I_HALT));
        hwrite(2, 4, 32'(e_brz(0, -1)));
        hwrite(2, 5, 32'(I_HALT));
        run("R8");
        check("R8 halt pc", 32'(pc), 32'd3);
        hread(1, 20, v); check("R8 skipped marker", v, 32'hDEAD);
    endtask

    task automatic t_halt_nop();
        logic [31:0] v;
        do_reset();
        hwrite(1, 22, 32'h5555);
        hwrite(0, 1, 32'h9);
        hwrite(2, 0, 32'(I_NOP));
        hwrite(2, 1, 32'(I_HALT));
        hwrite(2, 2, 32'(e_st(1, 22)));
        run("R11");
        check("R11 nop then halt pc", 32'(pc), 32'd1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 pc frozen", 32'(pc), 32'd1);
        check("R9 halted held", 32'(halted), 32'd1);
        hread(1, 22, v); check("R9 no store after halt", v, 32'h5555);
    endtask

    task automatic t_undef();
        do_reset();
        hwrite(2, 0, 32'h9000);
        hwrite(2, 1, 32'hF123);
        hwrite(2, 2, 32'(I_HALT));
        run("R10");
        check("R10 undefined as nop", 32'(pc), 32'd2);
    endtask

    task automatic t_late_write();
        logic [31:0] v;
        do_reset();
        hwrite(0, 6, 32'h2222);
        hwrite(1, 30, 32'h3333);
        hwrite(2, 0, 32'(I_HALT));
        run("R2");
        hwrite(0, 6, 32'h1111);
        hwrite(1, 30, 32'h4444);
        hwrite(2, 0, 32'(I_NOP));
        hread(0, 6, v);  check("R2 reg write ignored", v, 32'h2222);
        hread(1, 30, v); check("R2 data write ignored", v, 32'h3333);
        hread(2, 0, v);  check("R2 program write ignored", v, 32'(I_HALT));
    endtask

    bit finished = 0;

    initial begin
        t_reset();
        t_ld_st();
        t_cor();
        t_jmp();
        t_brz();
        t_halt_nop();
        t_undef();
        t_late_write();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule